// File: doc/BRIEF.md
# RTC Interrupt Emulation Sequencer

This block rebuilds the three interrupt sources of a classic real-time clock (once-per-second update, time-of-day alarm and periodic rate) on top of a one-shot comparator channel of a free-running counter. Each time the comparator reports a match (`tick`), the sequencer works out the next match target and requests a reload. It then evaluates the three sources against the current time of day and, when at least one fires, raises a one-cycle interrupt strobe with a flag word in the usual RTC layout.

The comparator is polled at a fixed base rate of 64 Hz, or at the requested periodic rate when the periodic source is enabled and that rate is higher. The periodic interrupt is a divide-down of the poll ticks. Each new target is the previous target plus one poll interval, so the tick cadence does not drift with service latency. The only exception is the first arm after all sources were off, which starts from the live counter value. Rates are held as base-2 exponents: exponent `e` means 2^e Hz.

Top module: `rtc_irq_emul`

## Requirements
- R1: After reset, `cmp_load`, `irq_stb`, `irq_flags` and `cmp_target` are all zero. The stored periodic exponent is 6 (64 Hz), the stored alarm is 00:00:00 and the recorded seconds value is 0.
- R2: The poll exponent is the stored periodic exponent when `en_periodic` is high and that exponent is greater than 6. Otherwise it is 6. The poll interval is `TICKS_PER_SEC >> poll_exponent`.
- R3: A `tick` while at least one enable is high and no fresh arm is due produces `cmp_load` = 1 on the next cycle. On that cycle `cmp_target` equals the previous `cmp_target` plus the poll interval, modulo 2^CW.
- R4: When the OR of the three enables is high in a cycle and was low in the cycle before, the next cycle carries `cmp_load` = 1 with `cmp_target` = `cnt_live` (sampled in that cycle) plus the poll interval. This takes priority over R3.
- R5: When all three enables are low, a `tick` is ignored: no `cmp_load`, no `irq_stb`, and `cmp_target` keeps its value.
- R6: On a serviced tick with `en_update` high, the update event fires if `tod_sec` differs from the recorded seconds value. The recorded value then becomes `tod_sec`. With `en_update` low, the recorded value is left as it is.
- R7: On a serviced tick with `en_alarm` high, the alarm event fires if `tod_hr`, `tod_min` and `tod_sec` all equal the stored alarm time.
- R8: On a serviced tick with `en_periodic` high, a divide counter advances by one. When it reaches 2^(poll_exponent − stored exponent), the periodic event fires and the counter returns to 0. With `en_periodic` low, the counter holds.
- R9: If any event fires, `irq_stb` is 1 on the cycle after the tick. `irq_flags` then holds 0x0100 (event count 1 in bits [15:8]) OR 0x80 (request) OR 0x10 for update, 0x20 for alarm and 0x40 for periodic, as fired. In every other cycle `irq_flags` is 0.
- R10: `freq_we` stores `freq_exp` clamped to the range 1..13 (2 Hz to 8192 Hz) and clears the divide counter.
- R11: The alarm time changes only on `alarm_we`. Values on the `alarm_*` inputs without the strobe have no effect on the alarm event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_update | input | 1 | Update (seconds change) source enable |
| en_alarm | input | 1 | Alarm source enable |
| en_periodic | input | 1 | Periodic source enable |
| freq_we | input | 1 | Write strobe for the periodic rate |
| freq_exp | input | 4 | Requested periodic rate exponent (2^n Hz) |
| alarm_we | input | 1 | Write strobe for the alarm time |
| alarm_hr | input | 5 | Alarm hours |
| alarm_min | input | 6 | Alarm minutes |
| alarm_sec | input | 6 | Alarm seconds |
| tod_hr | input | 5 | Current hours |
| tod_min | input | 6 | Current minutes |
| tod_sec | input | 6 | Current seconds |
| tick | input | 1 | One-cycle comparator match pulse |
| cnt_live | input | CW | Live main counter value |
| cmp_load | output | 1 | Request to load `cmp_target` into the comparator |
| cmp_target | output | CW | Next comparator target |
| irq_stb | output | 1 | Interrupt strobe |
| irq_flags | output | 16 | RTC-style flag word, valid with `irq_stb` |

## Verification
Every result is registered once: a tick or an enable rise sampled at one rising edge shows up on `cmp_load`, `cmp_target`, `irq_stb` and `irq_flags` right after that edge. The values stay for exactly one cycle, except `cmp_target`, which holds. Stimulus is driven on the falling edge. The bench samples outputs on the following falling edge, one cycle later, and also checks that the strobes are low again in the cycle after that. A reference model in the bench keeps the target, the recorded seconds value, the divide counter, the alarm and the rate exponent, and updates them only at the sampled edges.

// File: rtl/rtc_emu_pkg.sv
// Package: shared constants for the RTC interrupt emulation sequencer.
// Assumes a 16-bit flag word with the event count in bits [15:8].
package rtc_emu_pkg;
    localparam int EXPW     = 4;   // width of a rate exponent
    localparam int MIN_EXP  = 1;   // 2 Hz
    localparam int MAX_EXP  = 13;  // 8192 Hz
    localparam int BASE_EXP = 6;   // 64 Hz base poll rate

    localparam logic [15:0] FLG_UPDATE   = 16'h0010;
    localparam logic [15:0] FLG_ALARM    = 16'h0020;
    localparam logic [15:0] FLG_PERIODIC = 16'h0040;
    localparam logic [15:0] FLG_REQ      = 16'h0080;
    localparam logic [15:0] FLG_COUNT1   = 16'h0100;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } tod_t;
endpackage

// File: rtl/rtc_rate_sel.sv
// Rate selector: holds the requested periodic exponent and derives the
// poll exponent, the poll interval in counter ticks and the divide ratio.
// Assumes TICKS_PER_SEC is large enough that the interval is never zero.
module rtc_rate_sel
    import rtc_emu_pkg::*;
#(
    parameter int CW            = 32,
    parameter int TICKS_PER_SEC = 1048576,
    parameter int DIVW          = BASE_EXP - MIN_EXP + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_periodic,
    input  logic            freq_we,
    input  logic [EXPW-1:0] freq_exp,
    output logic [CW-1:0]   interval,
    output logic [DIVW-1:0] ratio
);
    localparam logic [CW-1:0]   CPS  = CW'(TICKS_PER_SEC);
    localparam logic [EXPW-1:0] BASE = EXPW'(BASE_EXP);
    localparam logic [EXPW-1:0] LO   = EXPW'(MIN_EXP);
    localparam logic [EXPW-1:0] HI   = EXPW'(MAX_EXP);

    logic [EXPW-1:0] fexp_q;
    logic [EXPW-1:0] poll_exp;

    // Store the requested exponent, clamped to the legal range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fexp_q <= BASE;
        else if (freq_we) begin
            if (freq_exp < LO)      fexp_q <= LO;
            else if (freq_exp > HI) fexp_q <= HI;
            else                    fexp_q <= freq_exp;
        end
    end

    // Pick the faster of base rate and requested rate, derive interval and ratio.
    always_comb begin
        poll_exp = (en_periodic && (fexp_q > BASE)) ? fexp_q : BASE;
        interval = CPS >> poll_exp;
        ratio    = DIVW'(1) << (poll_exp - fexp_q);
    end
endmodule

// File: rtl/rtc_rearm.sv
// Re-arm unit: keeps the comparator target and issues a load request.
// A fresh arm (enables rise from all-off) starts from the live counter;
// every later serviced tick advances from the previous target.
module rtc_rearm #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_en,
    input  logic          tick,
    input  logic [CW-1:0] cnt_live,
    input  logic [CW-1:0] interval,
    output logic          cmp_load,
    output logic [CW-1:0] cmp_target
);
    logic any_q;
    logic rise;

    // Remember the enable OR of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) any_q <= 1'b0;
        else        any_q <= any_en;
    end

    // Detect a transition from all-off to any-on.
    always_comb rise = any_en && !any_q;

    // Compute and request the next comparator target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_load   <= 1'b0;
            cmp_target <= '0;
        end else begin
            cmp_load <= 1'b0;
            if (rise) begin
                cmp_target <= cnt_live + interval;
                cmp_load   <= 1'b1;
            end else if (tick && any_en) begin
                cmp_target <= cmp_target + interval;
                cmp_load   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_event_eval.sv
// Event evaluator: on a serviced tick decides which of the update, alarm and
// periodic sources fire and emits the flag word with a one-cycle strobe.
// Assumes tod inputs are stable in the tick cycle.
module rtc_event_eval
    import rtc_emu_pkg::*;
#(
    parameter int DIVW = BASE_EXP - MIN_EXP + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            en_update,
    input  logic            en_alarm,
    input  logic            en_periodic,
    input  logic            alarm_we,
    input  tod_t            alarm_in,
    input  tod_t            tod,
    input  logic            freq_we,
    input  logic [DIVW-1:0] ratio,
    output logic            irq_stb,
    output logic [15:0]     irq_flags
);
    tod_t            alarm_q;
    logic [5:0]      last_sec;
    logic [DIVW-1:0] div_cnt;
    logic [DIVW-1:0] div_nxt;
    logic            go;
    logic            hit_upd;
    logic            hit_alm;
    logic            hit_per;
    logic [15:0]     flags_nxt;

    // Decide which sources fire on this tick.
    always_comb begin
        go        = tick && (en_update || en_alarm || en_periodic);
        div_nxt   = div_cnt + DIVW'(1);
        hit_upd   = go && en_update && (tod.sc != last_sec);
        hit_alm   = go && en_alarm && (tod == alarm_q);
        hit_per   = go && en_periodic && (div_nxt >= ratio);
        flags_nxt = (hit_upd ? FLG_UPDATE : 16'h0)
                  | (hit_alm ? FLG_ALARM : 16'h0)
                  | (hit_per ? FLG_PERIODIC : 16'h0);
        if (flags_nxt != 16'h0)
            flags_nxt = flags_nxt | FLG_REQ | FLG_COUNT1;
    end

    // Hold the alarm time written through the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        alarm_q <= '0;
        else if (alarm_we) alarm_q <= alarm_in;
    end

    // Track the last seconds value seen by the update source.
    always_ff @(posedge clk) begin
        if (!rst_n)                      last_sec <= '0;
        else if (go && en_update)        last_sec <= tod.sc;
    end

    // Divide poll ticks down to the periodic rate.
    always_ff @(posedge clk) begin
        if (!rst_n)                    div_cnt <= '0;
        else if (freq_we)              div_cnt <= '0;
        else if (go && en_periodic)    div_cnt <= hit_per ? '0 : div_nxt;
    end

    // Register the strobe and flag word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_stb   <= 1'b0;
            irq_flags <= '0;
        end else begin
            irq_stb   <= (flags_nxt != 16'h0);
            irq_flags <= flags_nxt;
        end
    end
endmodule

// File: rtl/rtc_irq_emul.sv
// Top: RTC interrupt emulation sequencer. Ties the rate selector, the
// re-arm unit and the event evaluator together. Assumes an external
// one-shot comparator that pulses tick once per match.
module rtc_irq_emul
    import rtc_emu_pkg::*;
#(
    parameter int CW            = 32,
    parameter int TICKS_PER_SEC = 1048576
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_update,
    input  logic          en_alarm,
    input  logic          en_periodic,
    input  logic          freq_we,
    input  logic [3:0]    freq_exp,
    input  logic          alarm_we,
    input  logic [4:0]    alarm_hr,
    input  logic [5:0]    alarm_min,
    input  logic [5:0]    alarm_sec,
    input  logic [4:0]    tod_hr,
    input  logic [5:0]    tod_min,
    input  logic [5:0]    tod_sec,
    input  logic          tick,
    input  logic [CW-1:0] cnt_live,
    output logic          cmp_load,
    output logic [CW-1:0] cmp_target,
    output logic          irq_stb,
    output logic [15:0]   irq_flags
);
    localparam int DIVW = BASE_EXP - MIN_EXP + 1;

    logic [CW-1:0]   interval;
    logic [DIVW-1:0] ratio;
    logic            any_en;
    tod_t            alarm_in;
    tod_t            tod;

    // Gather enables and time fields.
    always_comb begin
        any_en   = en_update || en_alarm || en_periodic;
        alarm_in = '{hr: alarm_hr, mn: alarm_min, sc: alarm_sec};
        tod      = '{hr: tod_hr, mn: tod_min, sc: tod_sec};
    end

    rtc_rate_sel #(.CW(CW), .TICKS_PER_SEC(TICKS_PER_SEC), .DIVW(DIVW)) u_rate (
        .clk(clk), .rst_n(rst_n), .en_periodic(en_periodic),
        .freq_we(freq_we), .freq_exp(freq_exp),
        .interval(interval), .ratio(ratio)
    );

    rtc_rearm #(.CW(CW)) u_rearm (
        .clk(clk), .rst_n(rst_n), .any_en(any_en), .tick(tick),
        .cnt_live(cnt_live), .interval(interval),
        .cmp_load(cmp_load), .cmp_target(cmp_target)
    );

    rtc_event_eval #(.DIVW(DIVW)) u_eval (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .en_update(en_update), .en_alarm(en_alarm), .en_periodic(en_periodic),
        .alarm_we(alarm_we), .alarm_in(alarm_in), .tod(tod),
        .freq_we(freq_we), .ratio(ratio),
        .irq_stb(irq_stb), .irq_flags(irq_flags)
    );
endmodule

// File: rtl/rtc_irq_emul_chk.sv
// Checker: temporal properties on the ports of rtc_irq_emul.
// Keeps one flop of its own to see rises of the enable OR.
module rtc_irq_emul_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_update,
    input logic          en_alarm,
    input logic          en_periodic,
    input logic          tick,
    input logic          cmp_load,
    input logic [CW-1:0] cmp_target,
    input logic          irq_stb,
    input logic [15:0]   irq_flags
);
    logic any_c;
    logic any_cq;

    // Enable OR as seen at the ports.
    always_comb any_c = en_update || en_alarm || en_periodic;

    // Previous-cycle enable OR.
    always_ff @(posedge clk) begin
        if (!rst_n) any_cq <= 1'b0;
        else        any_cq <= any_c;
    end

    AST_OFF_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !any_c) |=> (!cmp_load && !irq_stb && $stable(cmp_target))); // R5

    AST_LOAD_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && any_c) && !(any_c && !any_cq)) |=> !cmp_load); // R3

    AST_REARM_POW2_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && any_c && any_cq) |=> ($countones(cmp_target - $past(cmp_target)) == 1)); // R2

    AST_FLAG_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stb |-> (irq_flags[15:8] == 8'd1 && irq_flags[7] && (irq_flags[6:4] != 3'b000)
                     && irq_flags[3:0] == 4'd0)); // R9

    AST_FLAGS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_stb |-> (irq_flags == 16'h0)); // R9

    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !irq_stb); // R9

    AST_UPDATE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_update |=> !irq_flags[4]); // R6

    AST_ALARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_alarm |=> !irq_flags[5]); // R7

    AST_PERIODIC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_periodic |=> !irq_flags[6]); // R8
endmodule

bind rtc_irq_emul rtc_irq_emul_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_update(en_update), .en_alarm(en_alarm),
    .en_periodic(en_periodic), .tick(tick), .cmp_load(cmp_load),
    .cmp_target(cmp_target), .irq_stb(irq_stb), .irq_flags(irq_flags)
);

// File: tb/tb_rtc_irq_emul.sv
module tb_rtc_irq_emul;
    localparam int CW  = 32;
    localparam int CPS = 1048576;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_update = 0, en_alarm = 0, en_periodic = 0;
    logic          freq_we = 0;
    logic [3:0]    freq_exp = 0;
    logic          alarm_we = 0;
    logic [4:0]    alarm_hr = 0;
    logic [5:0]    alarm_min = 0, alarm_sec = 0;
    logic [4:0]    tod_hr = 0;
    logic [5:0]    tod_min = 0, tod_sec = 0;
    logic          tick = 0;
    logic [CW-1:0] cnt_live = 0;
    logic          cmp_load, irq_stb;
    logic [CW-1:0] cmp_target;
    logic [15:0]   irq_flags;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    logic [CW-1:0] m_target;
    logic [5:0]    m_last;
    int            m_div;
    int            m_fexp;
    logic [4:0]    m_ahr;
    logic [5:0]    m_amin, m_asec;
    logic          m_any;

    rtc_irq_emul #(.CW(CW), .TICKS_PER_SEC(CPS)) dut (.*);

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int poll_exp(input bit p, input int fe);
        return (p && fe > 6) ? fe : 6;
    endfunction

    function automatic logic [CW-1:0] intv(input bit p, input int fe);
        return CW'(CPS) >> poll_exp(p, fe);
    endfunction

    function automatic int clamp_exp(input int e);
        return (e < 1) ? 1 : ((e > 13) ? 13 : e);
    endfunction

    // Change enables; check fresh arm or absence of load one cycle later.
    task automatic set_en(input bit u, input bit a, input bit p, input logic [CW-1:0] live);
        bit any_new;
        logic [CW-1:0] exp_t;
        @(negedge clk);
        en_update = u; en_alarm = a; en_periodic = p; cnt_live = live;
        any_new = u | a | p;
        @(negedge clk);
        if (any_new && !m_any) begin
            exp_t = live + intv(p, m_fexp);
            check(cmp_load == 1'b1, "R4 fresh arm load", cmp_load, 1);
            check(cmp_target == exp_t, "R4 fresh arm target", cmp_target, exp_t);
            m_target = exp_t;
        end else begin
            check(cmp_load == 1'b0, "R4 no arm without rise", cmp_load, 0);
        end
        m_any = any_new;
    endtask

    task automatic write_freq(input int e);
        @(negedge clk);
        freq_we = 1; freq_exp = 4'(e);
        @(negedge clk);
        freq_we = 0;
        m_fexp = clamp_exp(e);
        m_div = 0;
    endtask

    task automatic write_alarm(input logic [4:0] h, input logic [5:0] m, input logic [5:0] s);
        @(negedge clk);
        alarm_we = 1; alarm_hr = h; alarm_min = m; alarm_sec = s;
        @(negedge clk);
        alarm_we = 0;
        m_ahr = h; m_amin = m; m_asec = s;
    endtask

    // One comparator tick with a given time of day; check all outputs.
    task automatic do_tick(input logic [4:0] h, input logic [5:0] m, input logic [5:0] s);
        logic [15:0] ef;
        logic [CW-1:0] et;
        bit go;
        int ratio;
        @(negedge clk);
        tick = 1; tod_hr = h; tod_min = m; tod_sec = s;
        go = en_update | en_alarm | en_periodic;
        ef = 16'h0;
        et = m_target;
        if (go) begin
            et = m_target + intv(en_periodic, m_fexp);
            if (en_update && s != m_last) ef |= 16'h0010;
            if (en_update) m_last = s;
            if (en_alarm && h == m_ahr && m == m_amin && s == m_asec) ef |= 16'h0020;
            if (en_periodic) begin
                ratio = 1 << (poll_exp(1, m_fexp) - m_fexp);
                m_div++;
                if (m_div >= ratio) begin ef |= 16'h0040; m_div = 0; end
            end
            if (ef != 0) ef |= 16'h0180;
        end
        @(negedge clk);
        tick = 0;
        check(cmp_load == go, go ? "R3 reload after tick" : "R5 tick ignored when off", cmp_load, go);
        check(cmp_target == et, go ? "R3 R2 next target" : "R5 target kept", cmp_target, et);
        check(irq_stb == (ef != 0), "R9 strobe", irq_stb, ef != 0);
        check(irq_flags == ef, "R6 R7 R8 R9 flags", irq_flags, ef);
        m_target = et;
        @(negedge clk);
        check(!cmp_load && !irq_stb && irq_flags == 0, "R9 single-cycle pulse", {cmp_load, irq_stb}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        m_target = 0; m_last = 0; m_div = 0; m_fexp = 6;
        m_ahr = 0; m_amin = 0; m_asec = 0; m_any = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!cmp_load && !irq_stb && irq_flags == 0 && cmp_target == 0, "R1 reset state",
              {cmp_load, irq_stb, irq_flags, cmp_target}, 0);

        // R5 tick with all sources off
        do_tick(5'd1, 6'd2, 6'd3);

        // R4 fresh arm, R6 update at 64 Hz interval (R2)
        set_en(1, 0, 0, 32'h1000_0000);
        do_tick(5'd1, 6'd2, 6'd3);
        do_tick(5'd1, 6'd2, 6'd3);   // same second: no update
        do_tick(5'd1, 6'd2, 6'd4);

        // R11 alarm inputs without strobe have no effect
        set_en(1, 1, 0, 32'h0);
        alarm_hr = 5'd7; alarm_min = 6'd8; alarm_sec = 6'd9;
        do_tick(5'd7, 6'd8, 6'd9);
        // R7 alarm through the strobe
        write_alarm(5'd7, 6'd8, 6'd10);
        do_tick(5'd7, 6'd8, 6'd10);
        do_tick(5'd7, 6'd8, 6'd10);

        // R8 periodic at 2 Hz: divide by 32; R10 clamp of 0 to 1
        write_freq(0);
        set_en(0, 0, 1, 32'h0);
        for (int i = 0; i < 34; i++) do_tick(5'd0, 6'd0, 6'd0);
        // R10 freq write clears divider
        write_freq(4);
        for (int i = 0; i < 5; i++) do_tick(5'd0, 6'd0, 6'd0);
        // R2 fast rate: clamp 15 -> 13 (8192 Hz), interval CPS>>13
        write_freq(15);
        do_tick(5'd0, 6'd0, 6'd0);
        do_tick(5'd0, 6'd0, 6'd0);

        // Fresh arm again after all off (R4)
        set_en(0, 0, 0, 32'h0);
        do_tick(5'd2, 6'd2, 6'd2);
        set_en(0, 0, 1, 32'hFFFF_FFF0);
        do_tick(5'd2, 6'd2, 6'd2);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 9);
            if (op == 0) begin
                set_en(1'($urandom), 1'($urandom), 1'($urandom), $urandom);
            end else if (op == 1) begin
                write_freq($urandom_range(0, 15));
            end else if (op == 2) begin
                write_alarm(5'($urandom_range(0, 23)), 6'($urandom_range(0, 59)),
                            6'($urandom_range(0, 59)));
            end else begin
                logic [4:0] h = 5'($urandom_range(0, 23));
                logic [5:0] m = 6'($urandom_range(0, 59));
                logic [5:0] s = 6'($urandom_range(0, 59));
                if ($urandom_range(0, 2) == 0) s = m_last;
                if ($urandom_range(0, 4) == 0) begin h = m_ahr; m = m_amin; s = m_asec; end
                do_tick(h, m, s);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule